// File: doc/BRIEF.md
# Dual-Clock FIFO Clear Sequencer

This controller clears an asynchronous FIFO's pointers in both clock domains, starting from one clear pulse in the write domain. While a clear is in progress it forces the FIFO to look full to writers and empty to readers. Each domain's pointer clear is issued at a point where the other side can neither push nor pop.

The write side raises a request level when a clear starts. The read side sees that level, clears its pointers and raises a hold level. When the write side sees the hold, it clears its own pointers and drops the request. The read side then drops its hold and emits a done pulse. Once the write side sees the hold go low, it lifts the forced-full state. Completion is never inferred from a synchronized pointer reading zero, because such a value may predate the clear. Each level that crosses between the domains passes through its own multi-flop synchronizer.

Top module: `dual_clock_clear_ctrl`

## Requirements
- R1: A `wr_clear_req` pulse seen at a write-clock edge while `wr_hold` is low sets `wr_hold` at that same edge. `wr_hold` stays high without a gap until the release in R5.
- R2: `rd_clear` is a one-read-cycle pulse issued only after the request level has been seen in the read domain. `rd_hold` rises with it and stays high through the next cycle and until R4.
- R3: `wr_clear` is a one-write-cycle pulse issued only after the read-side hold has been seen in the write domain. It therefore comes later than `rd_clear`.
- R4: `rd_hold` falls only after the write side has issued `wr_clear` and dropped its request level. `rd_clear_done` is high for exactly the first read cycle in which `rd_hold` is low again.
- R5: `wr_hold` falls only after `rd_hold` has fallen and that low level has been seen in the write domain.
- R6: A `wr_clear_req` that arrives while `wr_hold` is high is ignored. It adds no clear pulse and starts no second sequence.
- R7: Each reset is asynchronous and active low. While `wr_rst_n` is low, `wr_hold` and `wr_clear` are 0. While `rd_rst_n` is low, `rd_hold`, `rd_clear` and `rd_clear_done` are 0.
- R8: Each accepted request yields exactly one `rd_clear`, one `wr_clear`, one `rd_clear_done` and one fall of `wr_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_clear_req | input | 1 | Clear request pulse, write domain |
| wr_clear | output | 1 | One-cycle clear of the write pointers |
| wr_hold | output | 1 | Forces FIFO full while high |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_clear | output | 1 | One-cycle clear of the read pointers |
| rd_hold | output | 1 | Forces FIFO empty while high |
| rd_clear_done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The bench builds the block with `SYNC_STAGES` = 3, so every handshake leg takes longer and the windows for ignored requests are wide. The read clock first runs slower than the write clock and later faster, so the ordering of events is checked under both clock ratios. Extra request pulses are injected both before and after `wr_clear`. A reset is applied in the middle of a sequence to show that a later clear still completes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    W_IDLE    = 2'd0,
    W_REQ     = 2'd1,
    W_CLEAR   = 2'd2,
    W_RELEASE = 2'd3
  } wr_state_e;

  typedef enum logic [1:0] {
    R_IDLE  = 2'd0,
    R_CLEAR = 2'd1,
    R_HOLD  = 2'd2,
    R_DONE  = 2'd3
  } rd_state_e;

  // Write side: a start is only taken from idle; the peer hold level gates the
  // pointer clear and, once low again, the release.
  function automatic wr_state_e wr_next(wr_state_e s, logic start, logic peer_hold);
    wr_state_e n;
    n = s;
    case (s)
      W_IDLE:    if (start)      n = W_REQ;
      W_REQ:     if (peer_hold)  n = W_CLEAR;
      W_CLEAR:                   n = W_RELEASE;
      W_RELEASE: if (!peer_hold) n = W_IDLE;
      default:                   n = W_IDLE;
    endcase
    return n;
  endfunction

  // Read side: clear on a seen request, hold until the request goes away,
  // then one done cycle.
  function automatic rd_state_e rd_next(rd_state_e s, logic req_seen);
    rd_state_e n;
    n = s;
    case (s)
      R_IDLE:  if (req_seen)  n = R_CLEAR;
      R_CLEAR:                n = R_HOLD;
      R_HOLD:  if (!req_seen) n = R_DONE;
      R_DONE:                 n = R_IDLE;
      default:                n = R_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES < 2) begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], d};
      end
    end
  endgenerate

  assign q = chain[TOP];
endmodule

// File: rtl/dcc_wr_side.sv
module dcc_wr_side
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_req,
  input  logic peer_hold_seen,
  output logic hold,
  output logic ptr_clear,
  output logic req_level
);
  wr_state_e state_q, state_d;
  logic      hold_q, clear_q, req_q;

  assign state_d = wr_next(state_q, clear_req, peer_hold_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      hold_q  <= 1'b0;
      clear_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= (state_d != W_IDLE);
      clear_q <= (state_d == W_CLEAR);
      req_q   <= (state_d == W_REQ);
    end
  end

  assign hold      = hold_q;
  assign ptr_clear = clear_q;
  assign req_level = req_q;
endmodule

// File: rtl/dcc_rd_side.sv
module dcc_rd_side
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  output logic hold,
  output logic ptr_clear,
  output logic done
);
  rd_state_e state_q, state_d;
  logic      hold_q, clear_q, done_q;

  assign state_d = rd_next(state_q, req_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= R_IDLE;
      hold_q  <= 1'b0;
      clear_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= (state_d == R_CLEAR) || (state_d == R_HOLD);
      clear_q <= (state_d == R_CLEAR);
      done_q  <= (state_d == R_DONE);
    end
  end

  assign hold      = hold_q;
  assign ptr_clear = clear_q;
  assign done      = done_q;
endmodule

// File: rtl/dual_clock_clear_ctrl.sv
module dual_clock_clear_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic wr_clear_req,
  output logic wr_clear,
  output logic wr_hold,
  input  logic rd_clk,
  input  logic rd_rst_n,
  output logic rd_clear,
  output logic rd_hold,
  output logic rd_clear_done
);
  // Named crossing points, visible to the checker.
  logic wr_req_level;  // write domain, launched toward read
  logic rd_req_seen;   // read domain, synchronized request
  logic wr_hold_seen;  // write domain, synchronized read hold

  dcc_wr_side i_wr_side (
    .clk            (wr_clk),
    .rst_n          (wr_rst_n),
    .clear_req      (wr_clear_req),
    .peer_hold_seen (wr_hold_seen),
    .hold           (wr_hold),
    .ptr_clear      (wr_clear),
    .req_level      (wr_req_level)
  );

  dcc_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_req_level),
    .q     (rd_req_seen)
  );

  dcc_rd_side i_rd_side (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .req_seen  (rd_req_seen),
    .hold      (rd_hold),
    .ptr_clear (rd_clear),
    .done      (rd_clear_done)
  );

  dcc_sync #(.STAGES(SYNC_STAGES)) i_hold_sync (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_hold),
    .q     (wr_hold_seen)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
  input logic wr_clk,
  input logic wr_rst_n,
  input logic wr_clear_req,
  input logic wr_clear,
  input logic wr_hold,
  input logic wr_req_level,
  input logic wr_hold_seen,
  input logic rd_clk,
  input logic rd_rst_n,
  input logic rd_clear,
  input logic rd_hold,
  input logic rd_clear_done,
  input logic rd_req_seen
);
  // R1
  a_r1_hold_on_request: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_clear_req && !wr_hold) |=> wr_hold);

  // R2
  a_r2_rd_clear_after_req: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_clear |-> $past(rd_req_seen));
  a_r2_rd_clear_single: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_clear |=> (!rd_clear && rd_hold));

  // R3
  a_r3_wr_clear_after_hold: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_clear |-> $past(wr_hold_seen));
  a_r3_wr_clear_single: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_clear |=> (!wr_clear && wr_hold));

  // R4
  a_r4_hold_drop_after_req_low: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(rd_hold) |-> !$past(rd_req_seen));
  a_r4_done_on_release: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(rd_hold) |-> rd_clear_done);
  a_r4_done_single: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_clear_done |=> !rd_clear_done);

  // R5
  a_r5_release_after_peer_low: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(wr_hold) |-> !$past(wr_hold_seen));

  // R6
  a_r6_no_rerequest: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_clear_req && wr_hold && !wr_req_level) |=> !wr_req_level);

  // R7
  always @(posedge wr_clk) begin
    if (!wr_rst_n) a_r7_wr_reset_quiet: assert (!wr_hold && !wr_clear);
  end
  always @(posedge rd_clk) begin
    if (!rd_rst_n) a_r7_rd_reset_quiet: assert (!rd_hold && !rd_clear && !rd_clear_done);
  end
endmodule

bind dual_clock_clear_ctrl dcc_checker i_dcc_checker (
  .wr_clk        (wr_clk),
  .wr_rst_n      (wr_rst_n),
  .wr_clear_req  (wr_clear_req),
  .wr_clear      (wr_clear),
  .wr_hold       (wr_hold),
  .wr_req_level  (wr_req_level),
  .wr_hold_seen  (wr_hold_seen),
  .rd_clk        (rd_clk),
  .rd_rst_n      (rd_rst_n),
  .rd_clear      (rd_clear),
  .rd_hold       (rd_hold),
  .rd_clear_done (rd_clear_done),
  .rd_req_seen   (rd_req_seen)
);

// File: tb/test_dual_clock_clear_ctrl.sv
module test_dual_clock_clear_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_clear_req = 1'b0;
  logic wr_clear, wr_hold, rd_clear, rd_hold, rd_clear_done;
  realtime rd_half = 17.0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int n_wr_clear = 0, n_wr_fall = 0, n_rd_clear = 0, n_rd_fall = 0, n_done = 0;
  time t_wr_clear, t_wr_fall, t_rd_clear, t_rd_fall;
  logic wr_hold_prev = 1'b0, rd_hold_prev = 1'b0;

  always #10 wr_clk = ~wr_clk;          // 50 MHz write clock
  always #(rd_half) rd_clk = ~rd_clk;

  dual_clock_clear_ctrl #(.SYNC_STAGES(3)) i_dual_clock_clear_ctrl (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_clear_req(wr_clear_req),
    .wr_clear(wr_clear), .wr_hold(wr_hold),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_clear(rd_clear), .rd_hold(rd_hold), .rd_clear_done(rd_clear_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Event monitors, sampled away from the active edges.
  always @(negedge wr_clk) begin
    if (wr_rst_n) begin
      if (wr_clear) begin n_wr_clear++; t_wr_clear = $time; end
      if (wr_hold_prev && !wr_hold) begin n_wr_fall++; t_wr_fall = $time; end
    end
    wr_hold_prev = wr_hold;
  end

  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (rd_clear) begin
        n_rd_clear++; t_rd_clear = $time;
        check(rd_hold, "R2 hold with rd_clear", int'(rd_hold), 1);
      end
      if (rd_hold_prev && !rd_hold) begin
        n_rd_fall++; t_rd_fall = $time;
        check(rd_clear_done, "R4 done on hold release", int'(rd_clear_done), 1);
      end else if (rd_clear_done) begin
        check(1'b0, "R4 done without release", 1, 0);
      end
      if (rd_clear_done) n_done++;
    end
    rd_hold_prev = rd_hold;
  end

  task automatic wr_tick();
    @(negedge wr_clk); #1;
  endtask

  task automatic pulse_req();
    wr_clear_req = 1'b1;
    wr_tick();
    wr_clear_req = 1'b0;
  endtask

  task automatic do_reset();
    wr_rst_n = 1'b0; rd_rst_n = 1'b0; #1;
    check(!wr_hold && !wr_clear, "R7 write outputs in reset", int'({wr_hold, wr_clear}), 0);
    check(!rd_hold && !rd_clear && !rd_clear_done, "R7 read outputs in reset",
          int'({rd_hold, rd_clear, rd_clear_done}), 0);
    repeat (4) wr_tick();
    check(!wr_hold && !rd_hold, "R7 outputs stay low in reset", int'({wr_hold, rd_hold}), 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (3) wr_tick();
  endtask

  // One full clear; optional stray requests before and after wr_clear (R6).
  task automatic run_clear(input bit inject, input string tag);
    int b_wc = n_wr_clear, b_wf = n_wr_fall, b_rc = n_rd_clear, b_rf = n_rd_fall, b_dn = n_done;
    wr_tick();
    pulse_req();
    check(wr_hold, {"R1 hold after request ", tag}, int'(wr_hold), 1);
    if (inject) begin
      repeat (2) wr_tick();
      pulse_req();
      for (int i = 0; i < 400 && n_wr_clear == b_wc; i++) wr_tick();
      pulse_req();
    end
    for (int i = 0; i < 800 && n_wr_fall == b_wf; i++) wr_tick();
    check(n_wr_fall - b_wf == 1, {"R1 R5 single hold release ", tag}, n_wr_fall - b_wf, 1);
    check(n_rd_clear - b_rc == 1, {"R8 rd_clear count ", tag}, n_rd_clear - b_rc, 1);
    check(n_wr_clear - b_wc == 1, {"R8 wr_clear count ", tag}, n_wr_clear - b_wc, 1);
    check(n_done - b_dn == 1, {"R8 done count ", tag}, n_done - b_dn, 1);
    check(n_rd_fall - b_rf == 1, {"R2 rd_hold single release ", tag}, n_rd_fall - b_rf, 1);
    check(t_rd_clear < t_wr_clear, {"R3 wr_clear after rd_clear ", tag},
          int'(t_wr_clear), int'(t_rd_clear));
    check(t_wr_clear < t_rd_fall, {"R4 rd_hold falls after wr_clear ", tag},
          int'(t_rd_fall), int'(t_wr_clear));
    check(t_rd_fall < t_wr_fall, {"R5 wr_hold falls after rd_hold ", tag},
          int'(t_wr_fall), int'(t_rd_fall));
    repeat (40) wr_tick();
    check(!wr_hold && !rd_hold, {"R6 no follow-on sequence ", tag}, int'({wr_hold, rd_hold}), 0);
    check(n_wr_clear - b_wc == 1 && n_rd_clear - b_rc == 1,
          {"R6 no extra clears ", tag}, n_wr_clear - b_wc, 1);
  endtask

  task automatic reset_mid_sequence();
    pulse_req();
    repeat (6) wr_tick();
    check(wr_hold, "R1 hold before mid reset", int'(wr_hold), 1);
    do_reset();
    check(!wr_hold && !rd_hold, "R7 idle after mid reset", int'({wr_hold, rd_hold}), 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    do_reset();
    run_clear(1'b0, "slow read");
    run_clear(1'b1, "slow read, stray requests");
    rd_half = 7.0;
    repeat (4) wr_tick();
    run_clear(1'b0, "fast read");
    run_clear(1'b1, "fast read, stray requests");
    reset_mid_sequence();
    run_clear(1'b0, "after mid reset");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule